// File: doc/BRIEF.md
# Stepped Soft-Start Ramp Sequencer

This block sets the current-limit threshold of one switching-regulator channel while the channel starts up. It produces a small level code for an external converter that drives the current-limit comparator, and a flag that says the ramp is complete. Once the channel is running, each oscillator strobe advances an internal pulse counter. The level code follows that counter as a coarse staircase that climbs from zero to full scale in equal steps, then stays at full scale.

Shutdown, standby and a low enable each hold the counter at zero. The ramp therefore restarts from the bottom whenever the channel comes back. Oscillator strobes are single-cycle pulses in the system clock domain. The reset is asynchronous and active-low, and its release is synchronised inside the block.

Top module: `softstart_ramp`

## Requirements
- R1: While reset is asserted, and after it is released with the channel idle, the level code is 0 and the done flag is low.
- R2: With shutdown high, the pulse counter is cleared on the next clock edge and oscillator strobes are ignored. The level and done outputs read 0.
- R3: With standby high, the pulse counter is cleared on the next clock edge and oscillator strobes are ignored. The level and done outputs read 0.
- R4: With enable low, the pulse counter is cleared and oscillator strobes are ignored. The level and done outputs read 0.
- R5: The channel runs when enable is high and both shutdown and standby are low. While it runs, the counter advances by exactly one per strobe. Without a strobe the level code does not change, and it never rises by more than one step per clock.
- R6: The level code is a 3-bit unsigned value equal to floor(count*5/512). It reads 1, 2, 3 and 4 from counts 103, 205, 308 and 410, and is visible one clock after the strobe that reaches each count.
- R7: At 512 strobes the level code reaches 5, its full-scale value. Further strobes leave it at 5, and it never exceeds 5.
- R8: The done flag is high exactly when the level code is 5. It rises in the same cycle as the level and stays high until the channel stops running.
- R9: If the channel stops running in the middle of the ramp, the level returns to 0 on the next clock edge. A later restart begins again from a count of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Channel enable |
| shutdown | input | 1 | Shutdown indication, clears the ramp |
| standby | input | 1 | Standby indication, clears the ramp |
| osc_tick | input | 1 | One-cycle oscillator strobe |
| level | output | 3 | Current-limit level code, 0 to 5 |
| done | output | 1 | Ramp complete flag |

## Verification
All internal state lives in the pulse counter, so any wrong count reaches the level code no later than the next threshold crossing. The crossings are at 103, 205, 308, 410 and 512 strobes. A counter that misses a strobe, double-counts one or fails to clear therefore shows up as an early or late step, or as a nonzero level one clock after a stop. A wrong saturation shows up as a level above 5, or as the done flag disagreeing with the level, in the cycle it happens. The bench compares both outputs against its own count model after every clock.

// File: rtl/ss_pkg.sv
package ss_pkg;
  // Control decoded from the channel inputs for one clock.
  typedef struct packed {
    logic run;   // channel active
    logic step;  // strobe accepted this cycle
  } ss_ctrl_t;

  localparam int unsigned SS_STEPS_DEF = 5;
  localparam int unsigned SS_CLKS_DEF  = 512;
endpackage

// File: rtl/ss_rst_sync.sv
module ss_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/ss_pulse_counter.sv
module ss_pulse_counter
  import ss_pkg::*;
#(
  parameter int unsigned LIMIT = 512,
  parameter int unsigned CNT_W = $clog2(LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ss_ctrl_t         ctrl,
  output logic [CNT_W-1:0] count,
  output logic             full
);
  localparam logic [CNT_W-1:0] LIMIT_C = CNT_W'(LIMIT);

  logic [CNT_W-1:0] count_q, count_d;
  logic             count_en;

  assign full = (count_q == LIMIT_C);

  // Next state: clear when the channel stops, advance on accepted strobe.
  always_comb begin
    count_en = 1'b0;
    count_d  = count_q;
    if (!ctrl.run) begin
      count_en = (count_q != '0);
      count_d  = '0;
    end else if (ctrl.step && !full) begin
      count_en = 1'b1;
      count_d  = count_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count_q <= '0;
    else if (count_en) count_q <= count_d;
  end

  assign count = count_q;
endmodule

// File: rtl/ss_level_map.sv
module ss_level_map #(
  parameter int unsigned STEPS = 5,
  parameter int unsigned LIMIT = 512,
  parameter int unsigned CNT_W = $clog2(LIMIT + 1),
  parameter int unsigned LVL_W = $clog2(STEPS + 1)
) (
  input  logic [CNT_W-1:0] count,
  output logic [LVL_W-1:0] level
);
  localparam int unsigned PROD_W = CNT_W + LVL_W;
  localparam bit          POW2   = ((LIMIT & (LIMIT - 1)) == 0);

  logic [PROD_W-1:0] prod;
  logic [PROD_W-1:0] quot;

  assign prod = PROD_W'(count) * PROD_W'(STEPS);

  generate
    if (POW2) begin : g_shift
      assign quot = prod >> $clog2(LIMIT);
    end else begin : g_div
      assign quot = prod / PROD_W'(LIMIT);
    end
  endgenerate

  // Saturate at full scale.
  always_comb begin
    if (quot >= PROD_W'(STEPS)) level = LVL_W'(STEPS);
    else                        level = quot[LVL_W-1:0];
  end
endmodule

// File: rtl/softstart_ramp.sv
module softstart_ramp
  import ss_pkg::*;
#(
  parameter int unsigned STEPS = SS_STEPS_DEF,
  parameter int unsigned LIMIT = SS_CLKS_DEF,
  parameter int unsigned LVL_W = $clog2(STEPS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             shutdown,
  input  logic             standby,
  input  logic             osc_tick,
  output logic [LVL_W-1:0] level,
  output logic             done
);
  localparam int unsigned CNT_W = $clog2(LIMIT + 1);

  logic             rst_core_n;
  ss_ctrl_t         ctrl;
  logic [CNT_W-1:0] count;
  logic             full;

  ss_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  always_comb begin
    ctrl.run  = enable && !shutdown && !standby;
    ctrl.step = ctrl.run && osc_tick;
  end

  ss_pulse_counter #(.LIMIT(LIMIT), .CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_core_n),
    .ctrl  (ctrl),
    .count (count),
    .full  (full)
  );

  ss_level_map #(.STEPS(STEPS), .LIMIT(LIMIT), .CNT_W(CNT_W), .LVL_W(LVL_W)) u_map (
    .count (count),
    .level (level)
  );

  assign done = full;
endmodule

// File: rtl/ss_ramp_checker.sv
module ss_ramp_checker #(
  parameter int unsigned STEPS = 5,
  parameter int unsigned LVL_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             shutdown,
  input logic             standby,
  input logic             osc_tick,
  input logic [LVL_W-1:0] level,
  input logic             done
);
  localparam logic [LVL_W-1:0] TOP = LVL_W'(STEPS);

  assert_level_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    level <= TOP);

  assert_done_matches_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done == (level == TOP));

  assert_shutdown_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |=> (level == '0) && !done);

  assert_standby_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> (level == '0) && !done);

  assert_disable_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (level == '0) && !done);

  assert_hold_no_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !shutdown && !standby && !osc_tick) |=> $stable(level));

  assert_single_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !shutdown && !standby) |=>
      (level >= $past(level)) && (level <= $past(level) + LVL_W'(1)));
endmodule

bind softstart_ramp ss_ramp_checker #(.STEPS(STEPS), .LVL_W(LVL_W)) u_ramp_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .enable   (enable),
  .shutdown (shutdown),
  .standby  (standby),
  .osc_tick (osc_tick),
  .level    (level),
  .done     (done)
);

// File: tb/test_softstart_ramp.sv
module test_softstart_ramp;
  localparam time CLK_PERIOD = 10ns;
  localparam int  RAMP = 512;
  localparam int  WATCHDOG = 100000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       enable, shutdown, standby, osc_tick;
  logic [2:0] level;
  logic       done;

  int checks = 0;
  int fails  = 0;
  int mcnt   = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  softstart_ramp i_softstart_ramp (
    .clk(clk), .rst_n(rst_n), .enable(enable), .shutdown(shutdown),
    .standby(standby), .osc_tick(osc_tick), .level(level), .done(done)
  );

  function automatic int exp_level(int c);
    if (c >= RAMP) return 5;
    return (c * 5) / RAMP;
  endfunction

  task automatic check(string tag, int exp_l, bit exp_d);
    checks++;
    if (level !== 3'(exp_l)) begin
      fails++;
      $display("FAIL %s level actual=%0d expected=%0d (model count %0d)", tag, level, exp_l, mcnt);
    end
    checks++;
    if (done !== exp_d) begin
      fails++;
      $display("FAIL %s/R8 done actual=%0b expected=%0b (model count %0d)", tag, done, exp_d, mcnt);
    end
  endtask

  // Called at a negedge: drive, clock, update model, check at next negedge.
  task automatic cyc(bit en, bit sd, bit sb, bit tk, string tag);
    enable = en; shutdown = sd; standby = sb; osc_tick = tk;
    @(posedge clk);
    if (!(en && !sd && !sb)) mcnt = 0;
    else if (tk && mcnt < RAMP) mcnt++;
    @(negedge clk);
    check(tag, exp_level(mcnt), mcnt == RAMP);
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0123));
    rst_n = 1'b0; enable = 1'b0; shutdown = 1'b0; standby = 1'b0; osc_tick = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", 0, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 1, "R1");

    // Full ramp, one strobe per clock: thresholds R6, saturation R7.
    for (int i = 0; i < RAMP; i++) cyc(1, 0, 0, 1, (mcnt + 1 >= RAMP) ? "R7" : "R6");
    for (int i = 0; i < 20; i++) cyc(1, 0, 0, 1, "R7");
    for (int i = 0; i < 10; i++) cyc(1, 0, 0, 0, "R8");

    // Enable low clears, strobes ignored.
    for (int i = 0; i < 10; i++) cyc(0, 0, 0, 1, "R4");

    // Sparse strobes: hold between them.
    for (int i = 0; i < 300; i++) cyc(1, 0, 0, (i % 2) == 0, "R5");
    cyc(1, 1, 0, 1, "R2");
    for (int i = 0; i < 8; i++) cyc(1, 1, 0, 1, "R2");

    for (int i = 0; i < 330; i++) cyc(1, 0, 0, 1, "R6");
    cyc(1, 0, 1, 1, "R3");
    for (int i = 0; i < 8; i++) cyc(1, 0, 1, 1, "R3");

    // Mid-ramp stop and restart from zero.
    for (int i = 0; i < 250; i++) cyc(1, 0, 0, 1, "R6");
    cyc(0, 0, 0, 0, "R9");
    for (int i = 0; i < 104; i++) cyc(1, 0, 0, 1, "R9");

    // Constrained random phase.
    for (int i = 0; i < 6000; i++) begin
      int r = int'($urandom_range(0, 999));
      bit sd = (r < 3);
      bit sb = (r >= 3 && r < 6);
      bit en = !(r >= 6 && r < 9);
      bit tk = ($urandom_range(0, 99) < 70);
      cyc(en, sd, sb, tk, (sd ? "R2" : sb ? "R3" : !en ? "R4" : "R5"));
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule